// File: doc/BRIEF.md
# Per-Core Deterministic Store Buffer

This block is a private write buffer sitting beside one core in a deterministic multiprocessor. During the parallel phase of a round, every store from the core is captured locally and nothing reaches shared memory, so no other core can observe it. Loads from the owning core still see its own pending stores: a matching entry is merged byte by byte with the word that memory returned.

When the round controller grants this core its turn, a commit command drains the entries in allocation order through a valid/ready memory write port. The controller serialises commits across cores, so every write to a given address becomes visible in one global order. A store to an address that is already buffered is folded into that entry rather than taking a new slot. When a store needs a fresh slot and none is left, the block raises a trap line instead of stalling. So that the operating system can switch contexts at quantum boundaries, the whole buffer can be streamed out through a save port and later streamed back in through a restore port.

Top module: `det_store_buffer`

## Requirements
- R1: When no commit is running, the block never asserts `mem_wr_valid`. An accepted store (`st_ack`=1 in the cycle `st_valid` is high) is held only in the buffer, and `fill` counts the occupied entries.
- R2: After `commit_req` on a non-empty buffer, entries appear on the memory port in allocation order, one entry per cycle in which `mem_wr_valid` and `mem_wr_ready` are both high. Address, data and mask stay stable while `mem_wr_ready` is low.
- R3: `save_req` streams out the `fill` entries in allocation order, one per cycle with `sv_valid` high. `save_done` pulses in the cycle after the last one. The buffer contents are left unchanged.
- R4: `restore_req` discards the contents and loads min(`rs_count`, DEPTH) entries. One entry is taken from `rs_addr`/`rs_data`/`rs_mask` in each cycle that `rs_pull` is high. `restore_done` pulses when the restore completes.
- R5: A store to an address not held in the buffer, arriving while `fill` equals DEPTH, gets `full_trap`=1 and `st_ack`=0 in the same cycle and leaves the contents unchanged.
- R6: A store to an address that is already buffered is acknowledged even when the buffer is full. It replaces that entry's data and byte mask and leaves `fill` unchanged.
- R7: An accepted load (`ld_ok`=1) sets `ld_hit` when its address is buffered. For each byte i of `ld_data`, the result takes buffered data byte i (bits 8i+7..8i) when mask bit i is set, and `ld_mem_data` byte i otherwise.
- R8: `commit_done` pulses one cycle after the final write handshake, or one cycle after `commit_req` if the buffer is empty. At that point `fill` is 0 and `busy` is low.
- R9: While `busy` is high (commit, save or restore in progress), `st_ack` and `ld_ok` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_mask | input | DW/8 | Store byte enables |
| st_ack | output | 1 | Store accepted this cycle |
| full_trap | output | 1 | Store refused, no free entry |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_mem_data | input | DW | Word read from memory for the load |
| ld_ok | output | 1 | Load lookup accepted |
| ld_hit | output | 1 | Load address is buffered |
| ld_data | output | DW | Merged load data |
| commit_req | input | 1 | Start draining to memory |
| save_req | input | 1 | Start streaming contents out |
| restore_req | input | 1 | Start streaming contents in |
| rs_count | input | clog2(DEPTH+1) | Number of entries to restore |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts write |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| mem_wr_mask | output | DW/8 | Write byte enables |
| sv_valid | output | 1 | Saved entry present |
| sv_addr | output | AW | Saved entry address |
| sv_data | output | DW | Saved entry data |
| sv_mask | output | DW/8 | Saved entry mask |
| rs_pull | output | 1 | Restore entry is taken this cycle |
| rs_addr | input | AW | Restored entry address |
| rs_data | input | DW | Restored entry data |
| rs_mask | input | DW/8 | Restored entry mask |
| commit_done | output | 1 | Commit finished pulse |
| save_done | output | 1 | Save finished pulse |
| restore_done | output | 1 | Restore finished pulse |
| busy | output | 1 | Commit, save or restore running |
| fill | output | clog2(DEPTH+1) | Occupied entries |

## Verification
The bench targets the full boundary. It sends a fresh-address store that must trap, and a store to an address that is already buffered, which must still be folded into its entry. A design that counted the free slots before looking for a match would trap that second store wrongly. It commits with the memory ready line stalling, so a drain that skipped or repeated an entry, or reordered the entries, shows up as a scoreboard mismatch. It checks the exact cycle of the completion pulse, including the commit of an empty buffer, and pokes stores and loads while the drain runs. A restore request larger than the depth checks the clamp, and the follow-up commit checks that restored entries are published in the order they were pulled.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        SB_IDLE    = 2'd0,
        SB_COMMIT  = 2'd1,
        SB_SAVE    = 2'd2,
        SB_RESTORE = 2'd3
    } sb_state_e;

endpackage

// File: rtl/sb_match.sv
module sb_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int IW    = 2
) (
    input  logic [AW-1:0]             key,
    input  logic [DEPTH-1:0][AW-1:0]  tags,
    input  logic [DEPTH-1:0]          live,
    output logic                      hit,
    output logic [IW-1:0]             idx
);
    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = live[g] && (tags[g] == key);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sb_merge.sv
module sb_merge #(
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic [DW-1:0] mem_word,
    input  logic [DW-1:0] buf_word,
    input  logic [BW-1:0] buf_mask,
    input  logic          use_buf,
    output logic [DW-1:0] merged
);
    for (genvar b = 0; b < BW; b++) begin : g_byte
        assign merged[8*b +: 8] = (use_buf && buf_mask[b]) ? buf_word[8*b +: 8]
                                                            : mem_word[8*b +: 8];
    end
endmodule

// File: rtl/det_store_buffer.sv
module det_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_mask,
    output logic          st_ack,
    output logic          full_trap,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_mem_data,
    output logic          ld_ok,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    input  logic          commit_req,
    input  logic          save_req,
    input  logic          restore_req,
    input  logic [FW-1:0] rs_count,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic [BW-1:0] mem_wr_mask,
    output logic          sv_valid,
    output logic [AW-1:0] sv_addr,
    output logic [DW-1:0] sv_data,
    output logic [BW-1:0] sv_mask,
    output logic          rs_pull,
    input  logic [AW-1:0] rs_addr,
    input  logic [DW-1:0] rs_data,
    input  logic [BW-1:0] rs_mask,
    output logic          commit_done,
    output logic          save_done,
    output logic          restore_done,
    output logic          busy,
    output logic [FW-1:0] fill
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    typedef struct packed {
        sb_state_e                 state;
        logic [FW-1:0]             ptr;
        logic [FW-1:0]             fill;
        logic [FW-1:0]             tgt;
        logic                      cdone;
        logic                      sdone;
        logic                      rdone;
        logic [DEPTH-1:0][AW-1:0]  addr;
        logic [DEPTH-1:0][DW-1:0]  data;
        logic [DEPTH-1:0][BW-1:0]  mask;
    } sb_regs_t;

    sb_regs_t q, n;

    logic [DEPTH-1:0] live;
    logic             st_hit, ld_match, cmd_any, idle;
    logic [IW-1:0]    st_idx, ld_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live[i] = (FW'(i) < q.fill);
        end
    end

    sb_match #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_st_match (
        .key(st_addr), .tags(q.addr), .live(live), .hit(st_hit), .idx(st_idx)
    );

    sb_match #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_ld_match (
        .key(ld_addr), .tags(q.addr), .live(live), .hit(ld_match), .idx(ld_idx)
    );

    sb_merge #(.DW(DW)) u_merge (
        .mem_word(ld_mem_data),
        .buf_word(q.data[ld_idx]),
        .buf_mask(q.mask[ld_idx]),
        .use_buf (ld_hit),
        .merged  (ld_data)
    );

    assign idle    = (q.state == SB_IDLE);
    assign cmd_any = commit_req | save_req | restore_req;
    assign ld_ok   = ld_valid && idle && !cmd_any;
    assign ld_hit  = ld_ok && ld_match;

    always_comb begin
        n           = q;
        n.cdone     = 1'b0;
        n.sdone     = 1'b0;
        n.rdone     = 1'b0;
        st_ack      = 1'b0;
        full_trap   = 1'b0;
        mem_wr_valid = 1'b0;
        sv_valid    = 1'b0;
        rs_pull     = 1'b0;
        unique case (q.state)
            SB_IDLE: begin
                if (commit_req) begin
                    n.ptr = '0;
                    if (q.fill == '0) n.cdone = 1'b1;
                    else              n.state = SB_COMMIT;
                end else if (save_req) begin
                    n.ptr = '0;
                    if (q.fill == '0) n.sdone = 1'b1;
                    else              n.state = SB_SAVE;
                end else if (restore_req) begin
                    n.ptr  = '0;
                    n.fill = '0;
                    n.tgt  = (rs_count > FULL) ? FULL : rs_count;
                    if (n.tgt == '0) n.rdone = 1'b1;
                    else             n.state = SB_RESTORE;
                end else if (st_valid) begin
                    if (st_hit) begin
                        n.data[st_idx] = st_data;
                        n.mask[st_idx] = st_mask;
                        st_ack = 1'b1;
                    end else if (q.fill < FULL) begin
                        n.addr[q.fill[IW-1:0]] = st_addr;
                        n.data[q.fill[IW-1:0]] = st_data;
                        n.mask[q.fill[IW-1:0]] = st_mask;
                        n.fill = q.fill + 1'b1;
                        st_ack = 1'b1;
                    end else begin
                        full_trap = 1'b1;
                    end
                end
            end
            SB_COMMIT: begin
                mem_wr_valid = 1'b1;
                if (mem_wr_ready) begin
                    if (q.ptr == q.fill - 1'b1) begin
                        n.state = SB_IDLE;
                        n.fill  = '0;
                        n.cdone = 1'b1;
                    end else begin
                        n.ptr = q.ptr + 1'b1;
                    end
                end
            end
            SB_SAVE: begin
                sv_valid = 1'b1;
                if (q.ptr == q.fill - 1'b1) begin
                    n.state = SB_IDLE;
                    n.sdone = 1'b1;
                end else begin
                    n.ptr = q.ptr + 1'b1;
                end
            end
            SB_RESTORE: begin
                rs_pull = 1'b1;
                n.addr[q.ptr[IW-1:0]] = rs_addr;
                n.data[q.ptr[IW-1:0]] = rs_data;
                n.mask[q.ptr[IW-1:0]] = rs_mask;
                n.fill = q.ptr + 1'b1;
                if (q.ptr + 1'b1 == q.tgt) begin
                    n.state = SB_IDLE;
                    n.rdone = 1'b1;
                end else begin
                    n.ptr = q.ptr + 1'b1;
                end
            end
            default: n.state = SB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign mem_wr_addr  = q.addr[q.ptr[IW-1:0]];
    assign mem_wr_data  = q.data[q.ptr[IW-1:0]];
    assign mem_wr_mask  = q.mask[q.ptr[IW-1:0]];
    assign sv_addr      = q.addr[q.ptr[IW-1:0]];
    assign sv_data      = q.data[q.ptr[IW-1:0]];
    assign sv_mask      = q.mask[q.ptr[IW-1:0]];
    assign commit_done  = q.cdone;
    assign save_done    = q.sdone;
    assign restore_done = q.rdone;
    assign busy         = !idle;
    assign fill         = q.fill;

    // R1
    store_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_ack |-> !mem_wr_valid);

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_mask)));

    // R5
    trap_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_trap |-> (!st_ack && fill == FULL));

    // R5
    trap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_trap |=> $stable(fill));

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (fill == '0 && !busy));

    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!st_ack && !ld_ok));

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);
endmodule

// File: tb/tb_det_store_buffer.sv
module tb_det_store_buffer;
    localparam int DEPTH = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, ld_valid = 0, commit_req = 0, save_req = 0, restore_req = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0, rs_addr = '0;
    logic [DW-1:0] st_data = '0, ld_mem_data = '0, rs_data = '0;
    logic [BW-1:0] st_mask = '0, rs_mask = '0;
    logic [FW-1:0] rs_count = '0;
    logic mem_wr_ready = 1'b0;
    logic st_ack, full_trap, ld_ok, ld_hit, mem_wr_valid, sv_valid, rs_pull;
    logic commit_done, save_done, restore_done, busy;
    logic [DW-1:0] ld_data, mem_wr_data, sv_data;
    logic [AW-1:0] mem_wr_addr, sv_addr;
    logic [BW-1:0] mem_wr_mask, sv_mask;
    logic [FW-1:0] fill;

    det_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
        .st_ack(st_ack), .full_trap(full_trap),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mem_data(ld_mem_data),
        .ld_ok(ld_ok), .ld_hit(ld_hit), .ld_data(ld_data),
        .commit_req(commit_req), .save_req(save_req), .restore_req(restore_req),
        .rs_count(rs_count),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask),
        .sv_valid(sv_valid), .sv_addr(sv_addr), .sv_data(sv_data), .sv_mask(sv_mask),
        .rs_pull(rs_pull), .rs_addr(rs_addr), .rs_data(rs_data), .rs_mask(rs_mask),
        .commit_done(commit_done), .save_done(save_done), .restore_done(restore_done),
        .busy(busy), .fill(fill)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_hs = -1;
    bit finished = 0;

    logic [AW-1:0] m_a[$];
    logic [DW-1:0] m_d[$];
    logic [BW-1:0] m_m[$];
    logic [AW-1:0] e_a[$];
    logic [DW-1:0] e_d[$];
    logic [BW-1:0] e_m[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int find(input logic [AW-1:0] a);
        for (int i = 0; i < m_a.size(); i++) if (m_a[i] == a) return i;
        return -1;
    endfunction

    // memory ready pattern and cycle counter
    always @(negedge clk) begin
        cyc++;
        mem_wr_ready = (cyc % 3 != 0);
    end

    // monitor: pops expected writes as handshakes occur
    always @(negedge clk) begin
        #2;
        if (rst_n && mem_wr_valid && mem_wr_ready) begin
            if (e_a.size() == 0) begin
                chk(1'b0, "R1", "unexpected write addr", mem_wr_addr, 0);
            end else begin
                chk(mem_wr_addr === e_a[0], "R2", "wr addr", mem_wr_addr, e_a[0]);
                chk(mem_wr_data === e_d[0], "R2", "wr data", mem_wr_data, e_d[0]);
                chk(mem_wr_mask === e_m[0], "R2", "wr mask", mem_wr_mask, e_m[0]);
                void'(e_a.pop_front()); void'(e_d.pop_front()); void'(e_m.pop_front());
            end
            last_hs = cyc;
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] m);
        int i;
        bit ea;
        string tag;
        st_valid = 1; st_addr = a; st_data = d; st_mask = m;
        #3;
        i = find(a);
        ea = (i >= 0) || (m_a.size() < DEPTH);
        tag = !ea ? "R5" : (i >= 0 ? "R6" : "R1");
        chk(st_ack === ea, tag, "st_ack", st_ack, ea);
        chk(full_trap === !ea, "R5", "full_trap", full_trap, !ea);
        if (i >= 0) begin m_d[i] = d; m_m[i] = m; end
        else if (ea) begin m_a.push_back(a); m_d.push_back(d); m_m.push_back(m); end
        @(negedge clk);
        st_valid = 0;
        #3;
        chk(fill === FW'(m_a.size()), tag, "fill", fill, m_a.size());
        @(negedge clk);
    endtask

    task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] md);
        int i;
        logic [DW-1:0] ed;
        ld_valid = 1; ld_addr = a; ld_mem_data = md;
        #3;
        i = find(a);
        ed = md;
        if (i >= 0)
            for (int b = 0; b < BW; b++) if (m_m[i][b]) ed[8*b +: 8] = m_d[i][8*b +: 8];
        chk(ld_ok === 1'b1, "R7", "ld_ok", ld_ok, 1);
        chk(ld_hit === (i >= 0), "R7", "ld_hit", ld_hit, (i >= 0));
        chk(ld_data === ed, "R7", "ld_data", ld_data, ed);
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic do_commit(input bit probe);
        int req_cyc;
        int want;
        bit seen = 0;
        bit had = (m_a.size() != 0);
        foreach (m_a[i]) begin e_a.push_back(m_a[i]); e_d.push_back(m_d[i]); e_m.push_back(m_m[i]); end
        m_a.delete(); m_d.delete(); m_m.delete();
        commit_req = 1;
        #3;
        req_cyc = cyc;
        @(negedge clk);
        commit_req = 0;
        for (int t = 0; t < 200; t++) begin
            if (probe && t == 0) begin
                st_valid = 1; st_addr = 16'h7777; st_data = 32'h1; st_mask = 4'hF;
                ld_valid = 1; ld_addr = 16'h7777;
            end
            #3;
            if (probe && t == 0) begin
                chk(st_ack === 1'b0, "R9", "st_ack while busy", st_ack, 0);
                chk(ld_ok === 1'b0, "R9", "ld_ok while busy", ld_ok, 0);
                chk(busy === 1'b1, "R9", "busy", busy, 1);
            end
            if (commit_done) begin
                seen = 1;
                want = had ? last_hs + 1 : req_cyc + 1;
                chk(cyc == want, "R8", "commit_done cycle", cyc, want);
                chk(fill === '0, "R8", "fill after commit", fill, 0);
                chk(busy === 1'b0, "R8", "busy after commit", busy, 0);
            end
            @(negedge clk);
            st_valid = 0; ld_valid = 0;
            if (seen) break;
        end
        chk(seen, "R8", "commit_done seen", seen, 1);
        chk(e_a.size() == 0, "R2", "writes outstanding", e_a.size(), 0);
    endtask

    task automatic do_save();
        int k = 0;
        save_req = 1;
        #3;
        @(negedge clk);
        save_req = 0;
        for (int t = 0; t < 50; t++) begin
            #3;
            if (sv_valid) begin
                if (k < m_a.size()) begin
                    chk(sv_addr === m_a[k], "R3", "sv_addr", sv_addr, m_a[k]);
                    chk(sv_data === m_d[k], "R3", "sv_data", sv_data, m_d[k]);
                    chk(sv_mask === m_m[k], "R3", "sv_mask", sv_mask, m_m[k]);
                end
                k++;
            end
            if (save_done) break;
            @(negedge clk);
        end
        chk(k == m_a.size(), "R3", "saved count", k, m_a.size());
        chk(fill === FW'(m_a.size()), "R3", "fill after save", fill, m_a.size());
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] r_a(input int k); return AW'(16'h0400 + 16 * k); endfunction
    function automatic logic [DW-1:0] r_d(input int k); return 32'hA5000000 + DW'(k * 32'h010203); endfunction
    function automatic logic [BW-1:0] r_m(input int k); return BW'(4'b0011 << (k % 3)); endfunction

    task automatic do_restore(input int cnt);
        int k = 0;
        int en = (cnt > DEPTH) ? DEPTH : cnt;
        bit seen = 0;
        rs_count = FW'(cnt);
        restore_req = 1;
        #3;
        @(negedge clk);
        restore_req = 0;
        for (int t = 0; t < 50; t++) begin
            rs_addr = r_a(k); rs_data = r_d(k); rs_mask = r_m(k);
            #3;
            if (rs_pull) k++;
            if (restore_done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, "R4", "restore_done", seen, 1);
        chk(k == en, "R4", "pulled count", k, en);
        m_a.delete(); m_d.delete(); m_m.delete();
        for (int i = 0; i < en; i++) begin m_a.push_back(r_a(i)); m_d.push_back(r_d(i)); m_m.push_back(r_m(i)); end
        chk(fill === FW'(en), "R4", "fill after restore", fill, en);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #3;
        chk(fill === '0, "R1", "reset fill", fill, 0);
        chk(busy === 1'b0, "R9", "reset busy", busy, 0);
        chk(mem_wr_valid === 1'b0, "R1", "reset mem_wr_valid", mem_wr_valid, 0);
        @(negedge clk);

        do_store(16'h0010, 32'h11223344, 4'hF);
        do_store(16'h0020, 32'hAABBCCDD, 4'b0101);
        do_store(16'h0030, 32'h0BADF00D, 4'b1000);
        do_store(16'h0010, 32'h55667788, 4'b0110);
        do_load(16'h0010, 32'hFFFFFFFF);
        do_load(16'h0020, 32'h12345678);
        do_load(16'h0099, 32'hCAFEBABE);
        do_store(16'h0040, 32'hDEADBEEF, 4'hF);
        do_store(16'h0050, 32'h01010101, 4'hF);
        do_store(16'h0020, 32'h99999999, 4'b1110);
        do_load(16'h0020, 32'h00000000);
        do_save();
        do_commit(1'b1);
        do_load(16'h0010, 32'h0000FFFF);
        do_commit(1'b0);
        do_store(16'h0010, 32'h31313131, 4'b0001);
        do_commit(1'b0);
        do_restore(3);
        do_load(r_a(1), 32'h77777777);
        do_save();
        do_commit(1'b1);
        do_restore(6);
        do_store(16'h0999, 32'h1, 4'h1);
        do_store(r_a(3), 32'h87654321, 4'hF);
        do_commit(1'b0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule